// File: doc/BRIEF.md
# Configurable Interrupt Controller

This block gathers a vector of interrupt inputs and turns them into two request lines for a processor. Each input passes through a two-stage synchronizer. Its trigger behaviour comes from a 3-bit code, and that code is spread across three bit-plane registers. The code selects one of: disabled, rising edge, falling edge, both edges, active-high level or active-low level. Edge events are held in sticky rising and falling capture registers until software clears them. Level sources follow the synchronized input.

A per-source mask gates whether a source may request at all. A per-source steering bit sends an enabled source either to the preferred request line (request 0) or to the other one (request 1). Each request output is the OR of its own pending bitmap, and both bitmaps can be read over the register port.

The wake-enable, source-select and scratch test registers are storage that reads back; no logic inside the block uses them. Every configuration register is changed through a pair of addresses: one sets bits and one clears them. Some addresses return one thing on a read and do something else on a write.

Top module: `irqc_top`

## Requirements
- R1: While `rst` is high, and after it is released, the trigger planes, mask, steering, wake, capture and test registers read 0. The source-select register reads all ones. Both pending bitmaps read 0 and `req0_o`/`req1_o` are low.
- R2: Each configurable register has a set address and a clear address. A 1 written to the set address sets that bit, and a 1 written to the clear address clears it; 0 bits leave the register unchanged. The pairs are: plane0 0x40/0x44, plane1 0x48/0x4C, plane2 0x50/0x54, source-select 0x58/0x5C, steering 0x60/0x64, wake 0x68/0x6C, mask 0x70/0x74.
- R3: A read with `bus_rd` high at a clock edge puts data on `bus_rdata` after that edge. The read map is: plane0 0x40, plane1 0x48, plane2 0x50, request-0 pending 0x54, source-select 0x58, request-1 pending 0x5C, steering 0x60, wake 0x68, mask 0x70, rising capture 0x78, falling capture 0x7C, test 0x80.
- R4: The trigger code {plane2,plane1,plane0} of a source is decoded as follows: 001 rising, 010 falling, 011 both edges, 101 high level, 110 low level. The codes 000, 100 and 111 disable the source: it captures nothing and never becomes pending.
- R5: In level modes, the pending bit of an enabled source equals the synchronized input in high mode and its inverse in low mode.
- R6: In edge modes, a matching edge sets the source's bit in the rising (0x78) or falling (0x7C) capture register. The bit stays set until a 1 is written to that same address, and the source is pending while a capture bit matching its mode is set.
- R7: If an edge is detected in the same cycle as a capture-clear write to that bit, the bit ends up set.
- R8: A source with mask bit 0 is never pending and cannot drive either request output. Its capture bits are still recorded.
- R9: A pending source whose steering bit is 1 appears in the request-0 bitmap. If its steering bit is 0 it appears in the request-1 bitmap instead.
- R10: `req0_o` and `req1_o` are high exactly when their pending bitmaps are non-zero.
- R11: The 32-bit test register at 0x80 is loaded by a write and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 32 | Asynchronous interrupt inputs |
| req0_o | output | 1 | Preferred request line |
| req1_o | output | 1 | Secondary request line |

## Verification
The set/clear register pairs are swept with several overlapping bit patterns. This separates true set/clear behaviour from a plain overwrite and exposes any aliasing between neighbouring addresses.

All eight trigger codes are run through a complete high-then-low pulse on two different sources. This shows which codes capture which edge, whether a capture stays sticky, and whether level polarity is right.

A one-hot sweep over all 32 inputs in high-level mode, with a mixed steering pattern, checks the routing to the request lines and the mask gating of every bit. A clear write placed on the exact cycle an edge is detected shows that the edge takes priority over the clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_PL0_SET  = 8'h40;
  localparam logic [ADDR_W-1:0] A_PL0_CLR  = 8'h44;
  localparam logic [ADDR_W-1:0] A_PL1_SET  = 8'h48;
  localparam logic [ADDR_W-1:0] A_PL1_CLR  = 8'h4C;
  localparam logic [ADDR_W-1:0] A_PL2_SET  = 8'h50;
  localparam logic [ADDR_W-1:0] A_PL2_CLR  = 8'h54; // read: request-0 pending
  localparam logic [ADDR_W-1:0] A_SEL_SET  = 8'h58;
  localparam logic [ADDR_W-1:0] A_SEL_CLR  = 8'h5C; // read: request-1 pending
  localparam logic [ADDR_W-1:0] A_STR_SET  = 8'h60;
  localparam logic [ADDR_W-1:0] A_STR_CLR  = 8'h64;
  localparam logic [ADDR_W-1:0] A_WAK_SET  = 8'h68;
  localparam logic [ADDR_W-1:0] A_WAK_CLR  = 8'h6C;
  localparam logic [ADDR_W-1:0] A_MSK_SET  = 8'h70;
  localparam logic [ADDR_W-1:0] A_MSK_CLR  = 8'h74;
  localparam logic [ADDR_W-1:0] A_RISE     = 8'h78;
  localparam logic [ADDR_W-1:0] A_FALL     = 8'h7C;
  localparam logic [ADDR_W-1:0] A_TEST     = 8'h80;

  typedef struct packed {
    logic rise_en;
    logic fall_en;
    logic lvl_en;
    logic lvl_high;
  } trig_t;

  function automatic trig_t decode_trig(input logic [2:0] code);
    trig_t t;
    t.rise_en  = ~code[2] & code[0];
    t.fall_en  = ~code[2] & code[1];
    t.lvl_en   = code[2] & (code[1] ^ code[0]);
    t.lvl_high = code[0];
    return t;
  endfunction
endpackage

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  // R6: a detected rising edge means the synchronized level was low one cycle earlier
  a_r6_rise_from_low: assert property (@(posedge clk) disable iff (rst)
    (|rise) |-> ((rise & $past(s2_q)) == '0));
endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic       rise_det,
  input  logic       fall_det,
  input  logic [2:0] code,
  input  logic       mask,
  input  logic       clr_rise,
  input  logic       clr_fall,
  output logic       rise_q,
  output logic       fall_q,
  output logic       pend_nxt
);
  trig_t t;
  logic  rise_n, fall_n, raw;

  always_comb begin
    t      = decode_trig(code);
    rise_n = (t.rise_en & rise_det) | (rise_q & ~clr_rise);
    fall_n = (t.fall_en & fall_det) | (fall_q & ~clr_fall);
    if (t.lvl_en) raw = t.lvl_high ? lvl : ~lvl;
    else          raw = (t.rise_en & rise_n) | (t.fall_en & fall_n);
    pend_nxt = raw & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= rise_n;
      fall_q <= fall_n;
    end
  end

  // R6: a captured edge stays until a clear is written
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (rise_q && !clr_rise) |=> rise_q);
  // R4: a disabled code never captures a new edge
  a_r4_no_capture: assert property (@(posedge clk) disable iff (rst)
    ((code == 3'b000) && !rise_q && !fall_q) |=> (!rise_q && !fall_q));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              req0_o,
  output logic              req1_o
);
  localparam logic [NSRC-1:0] ALL_ONES = '1;

  logic [NSRC-1:0] pl0_q, pl1_q, pl2_q, sel_q, str_q, wak_q, msk_q;
  logic [NSRC-1:0] pend0_q, pend1_q, pend_nxt;
  logic [NSRC-1:0] rise_cap, fall_cap, lvl, rise_det, fall_det;
  logic [DW-1:0]   test_q, rd_mux;
  logic [NSRC-1:0] wv;
  logic            req0_q, req1_q;

  assign wv = bus_wdata[NSRC-1:0];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] ref_a,
                               input logic we);
    return we && (a == ref_a);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pl0_q  <= '0;
      pl1_q  <= '0;
      pl2_q  <= '0;
      sel_q  <= ALL_ONES;
      str_q  <= '0;
      wak_q  <= '0;
      msk_q  <= '0;
      test_q <= '0;
    end else begin
      if (hit(bus_addr, A_PL0_SET, bus_wr)) pl0_q <= pl0_q | wv;
      if (hit(bus_addr, A_PL0_CLR, bus_wr)) pl0_q <= pl0_q & ~wv;
      if (hit(bus_addr, A_PL1_SET, bus_wr)) pl1_q <= pl1_q | wv;
      if (hit(bus_addr, A_PL1_CLR, bus_wr)) pl1_q <= pl1_q & ~wv;
      if (hit(bus_addr, A_PL2_SET, bus_wr)) pl2_q <= pl2_q | wv;
      if (hit(bus_addr, A_PL2_CLR, bus_wr)) pl2_q <= pl2_q & ~wv;
      if (hit(bus_addr, A_SEL_SET, bus_wr)) sel_q <= sel_q | wv;
      if (hit(bus_addr, A_SEL_CLR, bus_wr)) sel_q <= sel_q & ~wv;
      if (hit(bus_addr, A_STR_SET, bus_wr)) str_q <= str_q | wv;
      if (hit(bus_addr, A_STR_CLR, bus_wr)) str_q <= str_q & ~wv;
      if (hit(bus_addr, A_WAK_SET, bus_wr)) wak_q <= wak_q | wv;
      if (hit(bus_addr, A_WAK_CLR, bus_wr)) wak_q <= wak_q & ~wv;
      if (hit(bus_addr, A_MSK_SET, bus_wr)) msk_q <= msk_q | wv;
      if (hit(bus_addr, A_MSK_CLR, bus_wr)) msk_q <= msk_q & ~wv;
      if (hit(bus_addr, A_TEST,    bus_wr)) test_q <= bus_wdata;
    end
  end

  irqc_sync_edge #(.W(NSRC)) u_sync (
    .clk(clk), .rst(rst), .din(src_in),
    .lvl(lvl), .rise(rise_det), .fall(fall_det)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irqc_src_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .lvl      (lvl[i]),
      .rise_det (rise_det[i]),
      .fall_det (fall_det[i]),
      .code     ({pl2_q[i], pl1_q[i], pl0_q[i]}),
      .mask     (msk_q[i]),
      .clr_rise (hit(bus_addr, A_RISE, bus_wr) && bus_wdata[i]),
      .clr_fall (hit(bus_addr, A_FALL, bus_wr) && bus_wdata[i]),
      .rise_q   (rise_cap[i]),
      .fall_q   (fall_cap[i]),
      .pend_nxt (pend_nxt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend0_q <= '0;
      pend1_q <= '0;
      req0_q  <= 1'b0;
      req1_q  <= 1'b0;
    end else begin
      pend0_q <= pend_nxt & str_q;
      pend1_q <= pend_nxt & ~str_q;
      req0_q  <= |(pend_nxt & str_q);
      req1_q  <= |(pend_nxt & ~str_q);
    end
  end

  assign req0_o = req0_q;
  assign req1_o = req1_q;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_PL0_SET: rd_mux[NSRC-1:0] = pl0_q;
      A_PL1_SET: rd_mux[NSRC-1:0] = pl1_q;
      A_PL2_SET: rd_mux[NSRC-1:0] = pl2_q;
      A_PL2_CLR: rd_mux[NSRC-1:0] = pend0_q;
      A_SEL_SET: rd_mux[NSRC-1:0] = sel_q;
      A_SEL_CLR: rd_mux[NSRC-1:0] = pend1_q;
      A_STR_SET: rd_mux[NSRC-1:0] = str_q;
      A_WAK_SET: rd_mux[NSRC-1:0] = wak_q;
      A_MSK_SET: rd_mux[NSRC-1:0] = msk_q;
      A_RISE:    rd_mux[NSRC-1:0] = rise_cap;
      A_FALL:    rd_mux[NSRC-1:0] = fall_cap;
      A_TEST:    rd_mux = test_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R1: request lines are low in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!req0_o && !req1_o));
  // R8: no pending bit for a source that was masked when it was evaluated
  a_r8_masked_idle: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pend0_q | pend1_q) & ~$past(msk_q)) == '0));
  // R2: a set write to the mask leaves every written bit set
  a_r2_mask_set: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_MSK_SET) |=> ((msk_q & $past(wv)) == $past(wv)));
  // R10: request-0 line agrees with its bitmap
  a_r10_req0_or: assert property (@(posedge clk) disable iff (rst)
    req0_o == (pend0_q != '0));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int NSRC = 32;
  localparam int DW   = 32;
  localparam time CYC = 20ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [NSRC-1:0] src_in = '0;
  logic          req0_o, req1_o;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  irqc_top #(.NSRC(NSRC), .DW(DW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .src_in(src_in), .req0_o(req0_o), .req1_o(req1_o)
  );

  always #(CYC/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic safe_init();
    wr(8'h44, '1); wr(8'h4C, '1); wr(8'h54, '1); wr(8'h64, '1);
    wr(8'h6C, '1); wr(8'h74, '1); wr(8'h58, '1);
    wr(8'h78, '1); wr(8'h7C, '1); wr(8'h80, '0);
  endtask

  initial begin
    #(CYC * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] set_a [7] = '{8'h40, 8'h48, 8'h50, 8'h58, 8'h60, 8'h68, 8'h70};
    logic [7:0] clr_a [7] = '{8'h44, 8'h4C, 8'h54, 8'h5C, 8'h64, 8'h6C, 8'h74};
    logic [31:0] pa [3] = '{32'hA5A5_0F0F, 32'h0000_FFFF, 32'h1234_8001};
    logic [31:0] pb [3] = '{32'h5A00_00F0, 32'hFFFF_0000, 32'h8000_0010};
    logic [31:0] pc [3] = '{32'h0F0F_F0F0, 32'h00FF_FF00, 32'hFFFF_FFFE};
    logic [31:0] steer;

    idle(3);
    // R1: values while reset is held
    chk("R1 req0 in reset", {31'b0, req0_o}, 0);
    @(negedge clk); rst = 1'b0;
    rd(8'h40, d); chk("R1 plane0", d, 0);
    rd(8'h48, d); chk("R1 plane1", d, 0);
    rd(8'h50, d); chk("R1 plane2", d, 0);
    rd(8'h54, d); chk("R1 pend0", d, 0);
    rd(8'h58, d); chk("R1 srcsel", d, '1);
    rd(8'h5C, d); chk("R1 pend1", d, 0);
    rd(8'h60, d); chk("R1 steer", d, 0);
    rd(8'h68, d); chk("R1 wake", d, 0);
    rd(8'h70, d); chk("R1 mask", d, 0);
    rd(8'h78, d); chk("R1 rising", d, 0);
    rd(8'h7C, d); chk("R1 falling", d, 0);
    rd(8'h80, d); chk("R1 test", d, 0);
    chk("R1 req pins", {30'b0, req1_o, req0_o}, 0);

    // R2 / R3: set-clear sweep over every pair
    for (int r = 0; r < 7; r++) begin
      for (int p = 0; p < 3; p++) begin
        wr(clr_a[r], '1);
        wr(set_a[r], pa[p]);
        rd(set_a[r], d); chk($sformatf("R2 set %h", set_a[r]), d, pa[p]);
        wr(set_a[r], pb[p]);
        rd(set_a[r], d); chk($sformatf("R2 set-or %h", set_a[r]), d, pa[p] | pb[p]);
        wr(clr_a[r], pc[p]);
        rd(set_a[r], d); chk($sformatf("R3 clear %h", set_a[r]), d, (pa[p] | pb[p]) & ~pc[p]);
      end
    end
    safe_init();

    // R11: test register
    wr(8'h80, 32'hDEAD_BEEF); rd(8'h80, d); chk("R11 test", d, 32'hDEAD_BEEF);
    wr(8'h80, 32'h0000_0001); rd(8'h80, d); chk("R11 test 2", d, 32'h0000_0001);

    // R4 R5 R6: every trigger code on two sources
    for (int si = 0; si < 2; si++) begin
      for (int m = 0; m < 8; m++) begin
        int s;
        logic [31:0] b;
        logic re, fe, lh, ll;
        s = (si == 0) ? 5 : 30;
        b = 32'h1 << s;
        re = (m == 1) || (m == 3);
        fe = (m == 2) || (m == 3);
        lh = (m == 5);
        ll = (m == 6);
        wr(8'h44, b); wr(8'h4C, b); wr(8'h54, b);
        if (m[0]) wr(8'h40, b);
        if (m[1]) wr(8'h48, b);
        if (m[2]) wr(8'h50, b);
        wr(8'h70, b); wr(8'h60, b);
        wr(8'h78, b); wr(8'h7C, b);
        idle(4);
        src_in[s] = 1'b1; idle(5);
        rd(8'h54, d); chk($sformatf("R5 pend hi m%0d", m), d & b, (lh || re) ? b : 0);
        rd(8'h78, d); chk($sformatf("R6 rise cap m%0d", m), d & b, re ? b : 0);
        src_in[s] = 1'b0; idle(5);
        rd(8'h7C, d); chk($sformatf("R6 fall cap m%0d", m), d & b, fe ? b : 0);
        rd(8'h54, d); chk($sformatf("R4 pend lo m%0d", m), d & b, (ll || re || fe) ? b : 0);
        wr(8'h78, b); wr(8'h7C, b); idle(3);
        rd(8'h54, d); chk($sformatf("R6 cleared m%0d", m), d & b, ll ? b : 0);
        chk($sformatf("R10 req0 m%0d", m), {31'b0, req0_o}, ll ? 1 : 0);
      end
    end
    safe_init();

    // R7: edge coinciding with clear write
    wr(8'h40, 32'h8); wr(8'h70, 32'h8); wr(8'h60, 32'h8);
    src_in[3] = 1'b1; idle(5); src_in[3] = 1'b0; idle(5);
    rd(8'h78, d); chk("R7 pre capture", d, 32'h8);
    @(negedge clk); src_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h78; bus_wdata = 32'h8; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(8'h78, d); chk("R7 edge wins", d, 32'h8);
    wr(8'h78, 32'h8); rd(8'h78, d); chk("R6 clear no edge", d, 0);
    src_in[3] = 1'b0; idle(4);

    // R8: masked edge still captured but not pending
    wr(8'h74, 32'h8);
    src_in[3] = 1'b1; idle(5);
    rd(8'h78, d); chk("R8 capture when masked", d, 32'h8);
    rd(8'h54, d); chk("R8 no pend when masked", d, 0);
    chk("R8 req0 low", {31'b0, req0_o}, 0);
    src_in[3] = 1'b0;
    safe_init();

    // R9 R10 R8: one-hot sweep with high-level mode on all sources
    steer = 32'hC3A5_5A3C;
    wr(8'h50, '1); wr(8'h40, '1); wr(8'h70, '1); wr(8'h60, steer);
    idle(4);
    for (int i = 0; i < NSRC; i++) begin
      logic [31:0] oh;
      oh = 32'h1 << i;
      src_in = oh; idle(5);
      rd(8'h54, d); chk($sformatf("R9 pend0 s%0d", i), d, oh & steer);
      rd(8'h5C, d); chk($sformatf("R9 pend1 s%0d", i), d, oh & ~steer);
      chk($sformatf("R10 pins s%0d", i), {30'b0, req1_o, req0_o},
          {30'b0, |(oh & ~steer), |(oh & steer)});
      wr(8'h74, oh); idle(3);
      chk($sformatf("R8 masked pins s%0d", i), {30'b0, req1_o, req0_o}, 0);
      wr(8'h70, oh);
      src_in = '0; idle(4);
    end
    chk("R5 all low idle", {30'b0, req1_o, req0_o}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule